// File: doc/BRIEF.md
# Four-Port Shared Memory with Per-Port Write Hold

A 2048 x 8 storage array reached through four identical read/write ports. All four ports share one clock. Each port has its own address, write data, read data and read-valid flag, plus four active-low controls: select, write, output enable and write hold. No port has priority for access, and the block does not arbitrate. The system around it must keep two ports from writing one word in the same cycle. The block raises a one-cycle flag when that happens and, so that the stored value is still predictable, keeps the data of the lowest-numbered port taking part. The read-valid flag stands in for a driven bus: when it is low, the read data is held at zero.

Each port runs a small mode machine. The mode register is loaded on every rising edge from that port's controls. Its modes are `PM_OFF` (deselected), `PM_HIDDEN` (read with outputs disabled), `PM_DRIVE` (read with outputs driven), `PM_WRITE` (write accepted) and `PM_INHIBIT` (write held off). The transitions are named after the control pattern that selects them:
- "deselect" goes to `PM_OFF`.
- "store" goes to `PM_WRITE`.
- "hold" goes to `PM_INHIBIT`.
- "show" goes to `PM_DRIVE`.
- "mute" goes to `PM_HIDDEN`.

Any mode can move to any other mode on the next edge. Reset forces `PM_OFF`.

Top module: `quad_port_ram`

## Requirements
- R1: Every port uses an 11-bit address and 8-bit data and can reach every one of the 2048 words, including word 0 and word 2047.
- R2: While `sel_n[p]` is high, port p performs no write and no read, and its `rd_valid[p]` is low on the following cycle.
- R3: With `sel_n[p]` low, `wr_n[p]` low and `hold_n[p]` high, the word at `addr[p]` takes `wdata[p]` at the rising edge, whatever the value of `oe_n[p]`.
- R4: With `sel_n[p]` low, `wr_n[p]` high and `oe_n[p]` low, `rd_valid[p]` is high on the next cycle and `rdata[p]` carries the addressed word.
- R5: A read with `oe_n[p]` high leaves `rd_valid[p]` low on the next cycle.
- R6: A write attempted with `hold_n[p]` low leaves the memory word unchanged. Reads on that port still work while `hold_n[p]` is low.
- R7: A port that is writing, whether accepted or held off, has `rd_valid[p]` low on the next cycle.
- R8: A read in the same cycle as another port's write to the same word returns the old value. The new value is returned from the next cycle on.
- R9: When two or more ports with `hold_n` high write one address in the same cycle, `collide` is high for exactly the next cycle, and the value stored is that of the lowest-numbered of those ports. Held-off writes and writes to different addresses do not raise `collide`.
- R10: During and after reset, all `rd_valid` bits and `collide` are low. Reset does not clear the memory contents.
- R11: `rdata[p]` is all zeros whenever `rd_valid[p]` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 4 | Per-port select, active low |
| wr_n | input | 4 | Per-port direction: low writes, high reads |
| oe_n | input | 4 | Per-port output enable, active low |
| hold_n | input | 4 | Per-port write hold, active low |
| addr | input | 4 x 11 | Per-port word address |
| wdata | input | 4 x 8 | Per-port write data |
| rdata | output | 4 x 8 | Per-port read data, zero when not valid |
| rd_valid | output | 4 | Per-port read data is being driven |
| collide | output | 1 | Same-address write clash seen in the previous cycle |

## Verification
The bench targets the two ends of the address range, the write-during-read case on one word, and a three-way write clash where port 0 stays idle. A design that let the highest port win, or that kept the wrong data, stores a value other than port 1's. A design that bypassed write data into reads would return the new byte one cycle early. The bench also holds a write with `hold_n` and then reads the same port: a write that leaks through, or a hold that also blocks reads, both show up as a wrong byte. Last, it re-asserts reset and reads back an earlier word, so a design that clears the array on reset is caught.

// File: rtl/qpr_pkg.sv
package qpr_pkg;

    typedef enum logic [2:0] {
        PM_OFF     = 3'd0,
        PM_HIDDEN  = 3'd1,
        PM_DRIVE   = 3'd2,
        PM_WRITE   = 3'd3,
        PM_INHIBIT = 3'd4
    } port_mode_e;

endpackage

// File: rtl/qpr_port_ctrl.sv
module qpr_port_ctrl
    import qpr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic              hold_n,
    input  logic [DATA_W-1:0] word_q,
    output logic              wr_req,
    output logic              rd_req,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rdata
);

    port_mode_e mode_d, mode_q;

    // next-mode decode from this cycle's controls
    always_comb begin
        unique casez ({sel_n, wr_n, oe_n, hold_n})
            4'b1???: mode_d = PM_OFF;      // deselect
            4'b00?1: mode_d = PM_WRITE;    // store
            4'b00?0: mode_d = PM_INHIBIT;  // hold
            4'b010?: mode_d = PM_DRIVE;    // show
            4'b011?: mode_d = PM_HIDDEN;   // mute
            default: mode_d = PM_OFF;
        endcase
    end

    assign wr_req = (mode_d == PM_WRITE);
    assign rd_req = (mode_d == PM_DRIVE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= PM_OFF;
        else        mode_q <= mode_d;
    end

    // outputs from the registered mode
    always_comb begin
        rd_valid = 1'b0;
        rdata    = '0;
        unique case (mode_q)
            PM_DRIVE: begin
                rd_valid = 1'b1;
                rdata    = word_q;
            end
            PM_OFF, PM_HIDDEN, PM_WRITE, PM_INHIBIT: begin
                rd_valid = 1'b0;
                rdata    = '0;
            end
            default: begin
                rd_valid = 1'b0;
                rdata    = '0;
            end
        endcase
    end

    assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !rd_valid);
    assert_read_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && wr_n && !oe_n) |=> rd_valid);
    assert_oe_mutes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && wr_n && oe_n) |=> !rd_valid);
    assert_write_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_n) |=> !rd_valid);

endmodule

// File: rtl/qpr_write_merge.sv
module qpr_write_merge #(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 11
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPORTS-1:0]            wr_req,
    input  logic [NPORTS-1:0][ADDR_W-1:0] addr,
    output logic [NPORTS-1:0]            wen,
    output logic                         collide
);

    logic [NPORTS-1:0] beaten;
    logic              clash;

    // a request loses when a lower-numbered port writes the same word
    always_comb begin
        for (int p = 0; p < NPORTS; p++) begin
            beaten[p] = 1'b0;
            for (int q = 0; q < NPORTS; q++) begin
                if (q < p && wr_req[q] && addr[q] == addr[p])
                    beaten[p] = 1'b1;
            end
            wen[p] = wr_req[p] && !beaten[p];
        end
    end

    assign clash = |(wr_req & beaten);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) collide <= 1'b0;
        else        collide <= clash;
    end

    generate
        for (genvar gp = 1; gp < NPORTS; gp++) begin : g_hi
            for (genvar gq = 0; gq < gp; gq++) begin : g_lo
                assert_lowest_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
                    (wr_req[gq] && wr_req[gp] && addr[gq] == addr[gp]) |-> !wen[gp]);
            end
        end
    endgenerate

endmodule

// File: rtl/qpr_ram_core.sv
module qpr_ram_core #(
    parameter int NPORTS = 4,
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic [NPORTS-1:0]            wen,
    input  logic [NPORTS-1:0]            ren,
    input  logic [NPORTS-1:0][ADDR_W-1:0] addr,
    input  logic [NPORTS-1:0][DATA_W-1:0] wdata,
    output logic [NPORTS-1:0][DATA_W-1:0] word_q
);

    logic [DATA_W-1:0] mem [DEPTH];

    // reads take the pre-edge contents; writes never overlap after merging
    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORTS; p++) begin
            if (wen[p]) mem[addr[p]] <= wdata[p];
            if (ren[p]) word_q[p]    <= mem[addr[p]];
        end
    end

endmodule

// File: rtl/quad_port_ram.sv
module quad_port_ram #(
    parameter int NPORTS = 4,
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORTS-1:0]             sel_n,
    input  logic [NPORTS-1:0]             wr_n,
    input  logic [NPORTS-1:0]             oe_n,
    input  logic [NPORTS-1:0]             hold_n,
    input  logic [NPORTS-1:0][ADDR_W-1:0] addr,
    input  logic [NPORTS-1:0][DATA_W-1:0] wdata,
    output logic [NPORTS-1:0][DATA_W-1:0] rdata,
    output logic [NPORTS-1:0]             rd_valid,
    output logic                          collide
);

    logic [NPORTS-1:0]             wr_req;
    logic [NPORTS-1:0]             rd_req;
    logic [NPORTS-1:0]             wen;
    logic [NPORTS-1:0][DATA_W-1:0] word_q;

    generate
        for (genvar gp = 0; gp < NPORTS; gp++) begin : g_port
            qpr_port_ctrl #(.DATA_W(DATA_W)) u_ctrl (
                .clk     (clk),
                .rst_n   (rst_n),
                .sel_n   (sel_n[gp]),
                .wr_n    (wr_n[gp]),
                .oe_n    (oe_n[gp]),
                .hold_n  (hold_n[gp]),
                .word_q  (word_q[gp]),
                .wr_req  (wr_req[gp]),
                .rd_req  (rd_req[gp]),
                .rd_valid(rd_valid[gp]),
                .rdata   (rdata[gp])
            );

            assert_hold_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (!sel_n[gp] && !wr_n[gp] && !hold_n[gp]) |-> !wen[gp]);
            assert_idle_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
                sel_n[gp] |-> !wen[gp]);
        end
    endgenerate

    qpr_write_merge #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (wr_req),
        .addr   (addr),
        .wen    (wen),
        .collide(collide)
    );

    qpr_ram_core #(.NPORTS(NPORTS), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_core (
        .clk   (clk),
        .wen   (wen),
        .ren   (rd_req),
        .addr  (addr),
        .wdata (wdata),
        .word_q(word_q)
    );

    assert_quiet_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid == '0) |-> (rdata == '0));

endmodule

// File: tb/quad_port_ram_test.sv
module quad_port_ram_test;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       sel_n = 4'hF;
    logic [3:0]       wr_n = 4'hF;
    logic [3:0]       oe_n = 4'hF;
    logic [3:0]       hold_n = 4'hF;
    logic [3:0][10:0] addr = '0;
    logic [3:0][7:0]  wdata = '0;
    logic [3:0][7:0]  rdata;
    logic [3:0]       rd_valid;
    logic             collide;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    quad_port_ram uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
        .hold_n(hold_n), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rd_valid(rd_valid), .collide(collide)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_all();
        sel_n = 4'hF; wr_n = 4'hF; oe_n = 4'hF; hold_n = 4'hF;
    endtask

    task automatic do_write(input int p, input logic [10:0] a, input logic [7:0] d);
        sel_n[p] = 1'b0; wr_n[p] = 1'b0; hold_n[p] = 1'b1; addr[p] = a; wdata[p] = d;
    endtask

    task automatic do_read(input int p, input logic [10:0] a);
        sel_n[p] = 1'b0; wr_n[p] = 1'b1; oe_n[p] = 1'b0; addr[p] = a;
    endtask

    task automatic t_reset();
        chk("R10 valid in reset", {28'd0, rd_valid}, 32'd0);
        chk("R10 collide in reset", {31'd0, collide}, 32'd0);
        rst_n = 1'b1;
        step();
        chk("R10 valid after reset", {28'd0, rd_valid}, 32'd0);
    endtask

    task automatic t_span();
        idle_all(); do_write(0, 11'd0, 8'hA5); step();
        idle_all(); do_write(1, 11'd2047, 8'h3C); step();
        idle_all(); do_read(3, 11'd0); step();
        chk("R1 word0 via port3 valid", {31'd0, rd_valid[3]}, 32'd1);
        chk("R1 word0 via port3", {24'd0, rdata[3]}, 32'hA5);
        idle_all(); do_read(2, 11'd2047); step();
        chk("R1 word2047 via port2", {24'd0, rdata[2]}, 32'h3C);
    endtask

    task automatic t_read_gate();
        idle_all(); do_read(1, 11'd0); oe_n[1] = 1'b1; step();
        chk("R5 muted read valid", {31'd0, rd_valid[1]}, 32'd0);
        chk("R11 muted read data", {24'd0, rdata[1]}, 32'd0);
        idle_all(); do_read(1, 11'd0); step();
        chk("R4 driven read", {23'd0, rd_valid[1], rdata[1]}, {23'd0, 1'b1, 8'hA5});
    endtask

    task automatic t_deselect();
        idle_all(); wr_n[0] = 1'b0; oe_n[0] = 1'b0; addr[0] = 11'd0; wdata[0] = 8'hFF; step();
        chk("R2 deselected valid", {31'd0, rd_valid[0]}, 32'd0);
        idle_all(); do_read(0, 11'd0); step();
        chk("R2 deselected write ignored", {24'd0, rdata[0]}, 32'hA5);
    endtask

    task automatic t_write_hiz();
        idle_all(); do_write(2, 11'd5, 8'h11); oe_n[2] = 1'b0; step();
        chk("R7 writer not driving", {31'd0, rd_valid[2]}, 32'd0);
        idle_all(); do_read(2, 11'd5); step();
        chk("R3 write with oe low stored", {24'd0, rdata[2]}, 32'h11);
    endtask

    task automatic t_busy();
        idle_all(); do_write(3, 11'd5, 8'h99); hold_n[3] = 1'b0; step();
        chk("R7 held writer not driving", {31'd0, rd_valid[3]}, 32'd0);
        chk("R9 held write no collide", {31'd0, collide}, 32'd0);
        idle_all(); do_read(3, 11'd5); hold_n[3] = 1'b0; step();
        chk("R6 held write blocked, read works", {23'd0, rd_valid[3], rdata[3]}, {23'd0, 1'b1, 8'h11});
    endtask

    task automatic t_same_cycle();
        idle_all(); do_write(0, 11'd9, 8'h40); step();
        idle_all(); do_write(0, 11'd9, 8'h41); do_read(1, 11'd9); step();
        chk("R8 same cycle old data", {24'd0, rdata[1]}, 32'h40);
        idle_all(); do_read(1, 11'd9); step();
        chk("R8 next cycle new data", {24'd0, rdata[1]}, 32'h41);
    endtask

    task automatic t_collide();
        idle_all();
        do_write(1, 11'd20, 8'h01); do_write(2, 11'd20, 8'h02); do_write(3, 11'd20, 8'h03);
        step();
        chk("R9 collide raised", {31'd0, collide}, 32'd1);
        idle_all(); do_read(0, 11'd20); step();
        chk("R9 collide one cycle", {31'd0, collide}, 32'd0);
        chk("R9 lowest port stored", {24'd0, rdata[0]}, 32'h01);
        idle_all(); do_write(0, 11'd30, 8'h07); do_write(1, 11'd31, 8'h08); step();
        chk("R9 distinct addresses no collide", {31'd0, collide}, 32'd0);
        idle_all(); do_write(0, 11'd21, 8'h55); do_write(1, 11'd21, 8'hAA); hold_n[1] = 1'b0; step();
        chk("R9 held peer no collide", {31'd0, collide}, 32'd0);
        idle_all(); do_read(2, 11'd21); do_read(3, 11'd31); step();
        chk("R9 unheld write kept", {24'd0, rdata[2]}, 32'h55);
        chk("R3 parallel write stored", {24'd0, rdata[3]}, 32'h08);
    endtask

    task automatic t_reset_keeps();
        idle_all(); do_read(1, 11'd9); step();
        rst_n = 1'b0; #2;
        chk("R10 reset clears valid", {28'd0, rd_valid}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        idle_all(); do_read(1, 11'd9); step();
        chk("R10 contents survive reset", {24'd0, rdata[1]}, 32'h41);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        t_span();
        t_read_gate();
        t_deselect();
        t_write_hiz();
        t_busy();
        t_same_cycle();
        t_collide();
        t_reset_keeps();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule